// File: doc/BRIEF.md
# Serial-Output ADC Behavioural Model

This block is a synthesizable stand-in for a multichannel converter whose samples leave the chip as serial lanes. It lets readout logic be exercised on silicon or in simulation without the real converter. A single fast clock runs at four times the serial bit rate. From it the block derives three kinds of output. The first is a frame clock that marks every 14-bit word. The second is a double-data-rate bit clock that toggles once per data bit. The third is one serial lane per channel that carries the word most significant bit first.

The word for each frame is picked by a three-bit source select. It can be a live per-channel sample input, saturated to the 14-bit range and coded as two's complement or offset binary. It can also be a fixed alternating pattern, all ones, all zeros, a user-supplied word, or a ramp that advances by one each frame. Configuration and samples are captured at the instant a frame is loaded, so a change during a frame never disturbs the word on the wire.

A five-state sequencer drives the timing:
- `ST_RESET` always moves to `ST_LAUNCH` and loads the first word.
- `ST_LAUNCH` (data changes), `ST_HOLD`, `ST_STROBE` (bit clock has just toggled) and `ST_SETTLE` repeat once per bit.
- `ST_SETTLE` returns to `ST_LAUNCH`. On the last bit of a frame it also loads the next word.

Top module: `adc_serial_model`

## Requirements
- R1: While `rst` is high, `frame_clk`, `bit_clk` and every lane are held at 0 from the first clock edge on.
- R2: A frame lasts 56 `clk` cycles (14 bits of 4 cycles). `frame_clk` is high for the first 7 bit periods and low for the last 7, and `bit_clk` is low when `frame_clk` rises.
- R3: `bit_clk` toggles exactly once per bit, 2 `clk` cycles after the data change, rising in the middle of even-numbered bits (counting from 0 at the frame start) and falling in the middle of odd ones. Lanes and `frame_clk` never change on the cycle `bit_clk` changes.
- R4: Each lane sends bit 13 first, starting with the `frame_clk` rise, then bits 12 down to 0, each held for 4 `clk` cycles.
- R5: Source select 0 with `cfg_offset_bin`=0 sends the channel's signed 16-bit sample in 14-bit two's complement, saturated: 0 gives 0x0000, values above 8191 give 0x1FFF, values below -8192 give 0x2000.
- R6: Source select 0 with `cfg_offset_bin`=1 sends offset binary, which is two's complement with bit 13 inverted: 0 gives 0x2000, positive overrange gives 0x3FFF, negative overrange gives 0x0000.
- R7: Source select 1 sends 0x2AAA, 2 sends 0x3FFF and 3 sends 0x0000 on every lane, whatever the sample and coding inputs.
- R8: Source select 4 sends `cfg_user` on every lane.
- R9: Source select 5 sends a ramp shared by all lanes that is one higher (modulo 2^14) in each successive frame.
- R10: Source select, coding, user word and samples are captured on the clock edge that loads a frame. Changing them during a frame leaves that frame's word unchanged, and the change takes effect in the next frame.
- R11: Source selects 6 and 7 behave like source select 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four times the serial bit rate |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode | input | 3 | Word source select (0 live, 1 alternating, 2 ones, 3 zeros, 4 user, 5 ramp) |
| cfg_offset_bin | input | 1 | 1 selects offset-binary coding of live samples; 0 selects two's complement |
| cfg_user | input | WORD_W (14) | User-defined word for source select 4 |
| samp_in | input | NCH*IN_W (64) | Signed samples, channel c in bits [c*IN_W +: IN_W] |
| frame_clk | output | 1 | Frame clock, high for the first half of each word |
| bit_clk | output | 1 | Double-data-rate bit clock centred on each data bit |
| lane_out | output | NCH (4) | Serial data, one lane per channel |

## Verification
The assertions take for granted that `rst` is driven synchronously and held for at least one clock edge at start-up, and that configuration and sample inputs only move away from the rising edge of `clk`. They make no assumption about when in a frame those inputs change. The stimulus keeps to these rules by changing every input on the falling edge. Most configuration changes fall on the last cycle of a frame. One deliberate change lands in mid-frame, to show that the loaded word is held. Random samples include values far outside the 14-bit range, so the saturation paths are exercised alongside the in-range codes.

// File: rtl/adc_model_pkg.sv
package adc_model_pkg;

    // Per-bit sequencing states of the serial timing generator
    typedef enum logic [2:0] {
        ST_RESET  = 3'd0,
        ST_LAUNCH = 3'd1,
        ST_HOLD   = 3'd2,
        ST_STROBE = 3'd3,
        ST_SETTLE = 3'd4
    } tick_state_e;

    // Word source selector values
    localparam logic [2:0] SRC_LIVE    = 3'd0;
    localparam logic [2:0] SRC_ALT     = 3'd1;
    localparam logic [2:0] SRC_ONES    = 3'd2;
    localparam logic [2:0] SRC_ZEROS   = 3'd3;
    localparam logic [2:0] SRC_USER    = 3'd4;
    localparam logic [2:0] SRC_RAMP    = 3'd5;

endpackage

// File: rtl/adc_tick_fsm.sv
module adc_tick_fsm
    import adc_model_pkg::*;
#(
    parameter int WORD_W = 14
) (
    input  logic clk,
    input  logic rst,
    output logic launch,
    output logic frame_load,
    output logic bit_clk,
    output logic frame_clk
);

    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);
    localparam logic [BIT_W-1:0] HALF_BIT = BIT_W'(WORD_W / 2);

    tick_state_e      st, st_nxt;
    logic [BIT_W-1:0] bit_idx, bit_nxt;

    // next-state logic
    always_comb begin
        st_nxt  = st;
        bit_nxt = bit_idx;
        unique case (st)
            ST_RESET: begin
                st_nxt  = ST_LAUNCH;
                bit_nxt = '0;
            end
            ST_LAUNCH: st_nxt = ST_HOLD;
            ST_HOLD:   st_nxt = ST_STROBE;
            ST_STROBE: st_nxt = ST_SETTLE;
            ST_SETTLE: begin
                st_nxt  = ST_LAUNCH;
                bit_nxt = (bit_idx == LAST_BIT) ? '0 : bit_idx + 1'b1;
            end
            default: st_nxt = ST_RESET;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_RESET;
            bit_idx <= '0;
        end else begin
            st      <= st_nxt;
            bit_idx <= bit_nxt;
        end
    end

    // a new bit is launched on the edge leaving RESET or SETTLE
    assign launch     = (st == ST_RESET) || (st == ST_SETTLE);
    assign frame_load = (st == ST_RESET) || ((st == ST_SETTLE) && (bit_idx == LAST_BIT));

    // output register: frame clock moves with data, bit clock two cycles later
    always_ff @(posedge clk) begin
        if (rst) begin
            frame_clk <= 1'b0;
            bit_clk   <= 1'b0;
        end else begin
            if (launch) begin
                frame_clk <= (bit_nxt < HALF_BIT);
            end
            if (st == ST_HOLD) begin
                bit_clk <= ~bit_clk;
            end
        end
    end

endmodule

// File: rtl/adc_word_src.sv
module adc_word_src
    import adc_model_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int WORD_W = 14,
    parameter int IN_W   = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    frame_load,
    input  logic [2:0]              cfg_mode,
    input  logic                    cfg_offset_bin,
    input  logic [WORD_W-1:0]       cfg_user,
    input  logic [NCH*IN_W-1:0]     samp_in,
    output logic [NCH*WORD_W-1:0]   word_flat
);

    localparam logic signed [IN_W-1:0] POS_LIM = IN_W'(2 ** (WORD_W - 1) - 1);
    localparam logic signed [IN_W-1:0] NEG_LIM = ~POS_LIM;
    localparam logic [WORD_W-1:0]      SIGN_FLIP = {1'b1, {(WORD_W - 1){1'b0}}};

    logic [WORD_W-1:0] ramp;
    logic [WORD_W-1:0] alt_pat;

    // ramp advances once per loaded frame
    always_ff @(posedge clk) begin
        if (rst) begin
            ramp <= '0;
        end else if (frame_load) begin
            ramp <= ramp + 1'b1;
        end
    end

    // alternating pattern: odd bit positions set
    for (genvar i = 0; i < WORD_W; i++) begin : g_alt
        assign alt_pat[i] = (i % 2) == 1;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic signed [IN_W-1:0] raw;
        logic [WORD_W-1:0]      clipped;
        logic [WORD_W-1:0]      live;
        logic [WORD_W-1:0]      pick;

        assign raw = samp_in[c*IN_W +: IN_W];

        always_comb begin
            if (raw > POS_LIM) begin
                clipped = POS_LIM[WORD_W-1:0];
            end else if (raw < NEG_LIM) begin
                clipped = NEG_LIM[WORD_W-1:0];
            end else begin
                clipped = raw[WORD_W-1:0];
            end
            live = cfg_offset_bin ? (clipped ^ SIGN_FLIP) : clipped;
        end

        always_comb begin
            case (cfg_mode)
                SRC_ALT:   pick = alt_pat;
                SRC_ONES:  pick = '1;
                SRC_ZEROS: pick = '0;
                SRC_USER:  pick = cfg_user;
                SRC_RAMP:  pick = ramp;
                default:   pick = live;
            endcase
        end

        assign word_flat[c*WORD_W +: WORD_W] = pick;
    end

endmodule

// File: rtl/adc_lane_ser.sv
module adc_lane_ser #(
    parameter int WORD_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic              frame_load,
    input  logic [WORD_W-1:0] word,
    output logic              lane
);

    logic [WORD_W-2:0] rest;

    always_ff @(posedge clk) begin
        if (rst) begin
            lane <= 1'b0;
            rest <= '0;
        end else if (frame_load) begin
            lane <= word[WORD_W-1];
            rest <= word[WORD_W-2:0];
        end else if (launch) begin
            lane <= rest[WORD_W-2];
            rest <= {rest[WORD_W-3:0], 1'b0};
        end
    end

endmodule

// File: rtl/adc_serial_model.sv
module adc_serial_model #(
    parameter int NCH    = 4,
    parameter int WORD_W = 14,
    parameter int IN_W   = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          cfg_mode,
    input  logic                cfg_offset_bin,
    input  logic [WORD_W-1:0]   cfg_user,
    input  logic [NCH*IN_W-1:0] samp_in,
    output logic                frame_clk,
    output logic                bit_clk,
    output logic [NCH-1:0]      lane_out
);

    logic                    launch;
    logic                    frame_load;
    logic [NCH*WORD_W-1:0]   word_flat;

    adc_tick_fsm #(.WORD_W(WORD_W)) i_tick (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .frame_load (frame_load),
        .bit_clk    (bit_clk),
        .frame_clk  (frame_clk)
    );

    adc_word_src #(.NCH(NCH), .WORD_W(WORD_W), .IN_W(IN_W)) i_src (
        .clk            (clk),
        .rst            (rst),
        .frame_load     (frame_load),
        .cfg_mode       (cfg_mode),
        .cfg_offset_bin (cfg_offset_bin),
        .cfg_user       (cfg_user),
        .samp_in        (samp_in),
        .word_flat      (word_flat)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        adc_lane_ser #(.WORD_W(WORD_W)) i_ser (
            .clk        (clk),
            .rst        (rst),
            .launch     (launch),
            .frame_load (frame_load),
            .word       (word_flat[c*WORD_W +: WORD_W]),
            .lane       (lane_out[c])
        );
    end

endmodule

// File: rtl/adc_serial_chk.sv
module adc_serial_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           frame_clk,
    input logic           bit_clk,
    input logic [NCH-1:0] lane_out,
    input logic           frame_load,
    input logic [2:0]     cfg_mode
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!frame_clk && !bit_clk && lane_out == '0));

    // R3
    bit_clk_centred_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(bit_clk) |-> ($stable(lane_out) && $stable(frame_clk)));

    // R2
    frame_start_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_clk) |-> !bit_clk);

    // R4
    lane_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(lane_out) |=> $stable(lane_out));

    // R7
    zero_pattern_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_load && cfg_mode == 3'd3) |=> (lane_out == '0));

endmodule

bind adc_serial_model adc_serial_chk #(.NCH(NCH)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_clk  (frame_clk),
    .bit_clk    (bit_clk),
    .lane_out   (lane_out),
    .frame_load (frame_load),
    .cfg_mode   (cfg_mode)
);

// File: tb/test_adc_serial_model.sv
module test_adc_serial_model;

    localparam int NCH = 4;
    localparam int WW  = 14;
    localparam int IW  = 16;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [2:0]          cfg_mode = 3'd0;
    logic                cfg_offset_bin = 1'b0;
    logic [WW-1:0]       cfg_user = '0;
    logic [NCH*IW-1:0]   samp_in = '0;
    logic                frame_clk;
    logic                bit_clk;
    logic [NCH-1:0]      lane_out;

    int checks = 0;
    int errors = 0;

    logic [WW-1:0] got [NCH];
    logic          fco_d = 1'b0;
    bit            poke = 1'b0;

    // configuration that the next loaded frame will use
    logic [2:0]    cur_mode;
    logic          cur_ob;
    logic [WW-1:0] cur_user;
    logic signed [IW-1:0] cur_samp [NCH];

    always #10 clk = ~clk;

    adc_serial_model #(.NCH(NCH), .WORD_W(WW), .IN_W(IW)) i_adc_serial_model (
        .clk            (clk),
        .rst            (rst),
        .cfg_mode       (cfg_mode),
        .cfg_offset_bin (cfg_offset_bin),
        .cfg_user       (cfg_user),
        .samp_in        (samp_in),
        .frame_clk      (frame_clk),
        .bit_clk        (bit_clk),
        .lane_out       (lane_out)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] expect_word(input logic [2:0] m, input logic ob,
                                                  input logic [WW-1:0] u,
                                                  input logic signed [IW-1:0] v);
        logic [WW-1:0] w;
        if (v > 16'sd8191)       w = 14'h1FFF;
        else if (v < -16'sd8192) w = 14'h2000;
        else                     w = v[WW-1:0];
        if (ob) w = w ^ 14'h2000;
        case (m)
            3'd1:    return 14'h2AAA;
            3'd2:    return 14'h3FFF;
            3'd3:    return 14'h0000;
            3'd4:    return u;
            default: return w;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] m, input logic ob);
        if (m == 3'd4) return "R8";
        if (m >= 3'd1 && m <= 3'd3) return "R7";
        if (m >= 3'd6) return "R11";
        return ob ? "R6" : "R5";
    endfunction

    task automatic apply(input logic [2:0] m, input logic ob, input logic [WW-1:0] u);
        cfg_mode = m;
        cfg_offset_bin = ob;
        cfg_user = u;
        cur_mode = m;
        cur_ob = ob;
        cur_user = u;
    endtask

    task automatic set_samp(input int c, input logic signed [IW-1:0] v);
        samp_in[c*IW +: IW] = v;
        cur_samp[c] = v;
    endtask

    // capture one complete frame starting at the frame clock rise
    task automatic grab();
        int fco_bad = 0;
        int dco_bad = 0;
        int hold_bad = 0;
        logic [NCH-1:0] bitval = '0;
        do begin
            @(negedge clk);
            if (frame_clk && !fco_d) break;
            fco_d = frame_clk;
        end while (1);
        for (int s = 0; s < 56; s++) begin
            if (s > 0) @(negedge clk);
            if (frame_clk !== (s < 28)) fco_bad++;
            if (bit_clk !== 1'(((s + 2) / 4) % 2)) dco_bad++;
            if (s % 4 == 0) begin
                bitval = lane_out;
                for (int c = 0; c < NCH; c++) got[c][13 - s / 4] = lane_out[c];
            end else if (lane_out !== bitval) begin
                hold_bad++;
            end
            if (poke && s == 20) cfg_mode = 3'd2;
        end
        fco_d = frame_clk;
        chk(fco_bad == 0, "R2 frame clock shape", fco_bad, 0);
        chk(dco_bad == 0, "R3 bit clock centring", dco_bad, 0);
        chk(hold_bad == 0, "R4 bit hold", hold_bad, 0);
    endtask

    task automatic check_words();
        for (int c = 0; c < NCH; c++) begin
            logic [WW-1:0] e;
            e = expect_word(cur_mode, cur_ob, cur_user, cur_samp[c]);
            chk(got[c] === e, tag_of(cur_mode, cur_ob), int'(got[c]), int'(e));
        end
    endtask

    initial begin
        logic [WW-1:0] prev;
        void'($urandom(32'd1234));
        apply(3'd0, 1'b0, '0);
        for (int c = 0; c < NCH; c++) set_samp(c, 16'sd0);
        repeat (4) @(negedge clk);
        // R1: reset holds outputs low
        chk(frame_clk === 1'b0 && bit_clk === 1'b0 && lane_out === '0,
            "R1 reset outputs", {frame_clk, bit_clk, lane_out}, 0);
        rst = 1'b0;

        grab();
        check_words();   // R5 zero input, default coding

        // R5: two's complement with saturation
        set_samp(0, 16'sd0); set_samp(1, 16'sd8191);
        set_samp(2, 16'sd9000); set_samp(3, -16'sd9000);
        grab(); grab(); check_words();
        set_samp(0, -16'sd8192); set_samp(1, 16'sd5); set_samp(2, -16'sd1); set_samp(3, 16'sd32767);
        grab(); check_words();

        // R6: offset binary
        apply(3'd0, 1'b1, '0);
        set_samp(0, 16'sd0); set_samp(1, 16'sd20000);
        set_samp(2, -16'sd20000); set_samp(3, -16'sd8192);
        grab(); check_words();

        // R7: fixed patterns
        for (int m = 1; m <= 3; m++) begin
            apply(3'(m), 1'b1, 14'h0123);
            grab(); check_words();
        end

        // R8: user word, MSB-first order visible (R4)
        apply(3'd4, 1'b0, 14'h1234);
        grab(); check_words();

        // R11: unused selectors behave as live
        apply(3'd6, 1'b1, '0);
        set_samp(0, 16'sd100); set_samp(1, -16'sd100); set_samp(2, 16'sd0); set_samp(3, 16'sd9999);
        grab(); check_words();
        apply(3'd7, 1'b0, '0);
        grab(); check_words();

        // R9: ramp steps by one each frame
        apply(3'd5, 1'b0, '0);
        grab(); grab();
        prev = got[0];
        for (int k = 0; k < 3; k++) begin
            grab();
            for (int c = 0; c < NCH; c++)
                chk(got[c] === prev + 1'b1, "R9 ramp step", int'(got[c]), int'(prev + 1'b1));
            prev = got[0];
        end

        // R10: mid-frame change does not touch the current word
        apply(3'd4, 1'b0, 14'h0F0F);
        grab();
        poke = 1'b1;
        grab();
        poke = 1'b0;
        chk(got[0] === 14'h0F0F, "R10 word held mid-frame", int'(got[0]), 14'h0F0F);
        cur_mode = 3'd2;
        grab(); check_words();   // R10 change applies next frame

        // random frames
        for (int k = 0; k < 20; k++) begin
            logic [2:0] m;
            m = 3'($urandom % 8);
            if (m == 3'd5) m = 3'd0;
            apply(m, 1'($urandom % 2), 14'($urandom));
            for (int c = 0; c < NCH; c++) set_samp(c, 16'($urandom));
            grab(); check_words();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule